// File: doc/BRIEF.md
# Peer Setup Message Decoder

This block decodes the control stream that a host-side coordinator sends to a shared-memory peer. Bytes arrive one per valid beat and are assembled into signed 64-bit messages, least significant byte first. A sideband flag, sampled on the beat that carries the eighth byte, tells whether a handle came with the message. Each message is acted on only once all eight bytes are in.

Setup follows a fixed order. The first message must be the protocol version. The second is this peer's own identifier. After that, every message is processed as a connect, a disconnect or a shared-memory announcement, until the value -1 marks the memory as present and ends setup. Later messages are still decoded as connects and disconnects. For each peer the block counts the vectors granted so far. The vector number is never carried in a message: a connect takes the next free slot for its peer. Decoded events appear as one-cycle pulses. Faults are reported through an error code that holds the most recent fault until reset.

Top module: `peer_msg_decoder`

## Requirements
- R1: A message is taken from eight valid beats, least significant byte first. Invalid cycles between beats are allowed. Nothing is decoded until the eighth beat, and the handle flag is sampled on that eighth beat. Decoded outputs change on the second clock edge after the edge that captures the eighth byte.
- R2: The first message must equal PROTO_VER and carry no handle. Otherwise err_code becomes 1 and all later input is ignored until reset.
- R3: The second message must carry no handle and lie in 0..65535. It is then shown on local_id. Otherwise err_code becomes 2 and all later input is ignored.
- R4: The first value of -1 after the identifier pulses mem_ready and setup_done together in the same cycle.
- R5: Any value below -1, or any value above 65535, sets err_code to 3 and produces no event.
- R6: A value of -1 that arrives after the memory is already present sets err_code to 4.
- R7: A non-negative value with a handle is a connect. It pulses conn_pulse with conn_peer set to the value and conn_vec set to the number of connects that peer already holds, and it raises that count by one. conn_local is 1 exactly when the peer equals local_id.
- R8: A connect for a peer that already holds NUM_VECS vectors sets err_code to 5, produces no event, and leaves the count unchanged.
- R9: A non-negative value without a handle is a disconnect. It pulses disc_pulse and resets that peer's count to zero. If the peer equals local_id, err_code becomes 6 and the count is kept.
- R10: peer_tbl_size is INIT_PEERS after reset. A connect or disconnect naming a peer at or above the current size grows it to peer+1. It never shrinks.
- R11: A peer value at or above MAX_PEERS sets err_code to 7. The table size and the counts stay unchanged, and no event is produced.
- R12: At most one of conn_pulse, disc_pulse and mem_ready is high in any cycle, and each pulse lasts one cycle per message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A message byte is present this cycle |
| in_byte | input | 8 | Message byte |
| in_handle | input | 1 | Handle attached; sampled on the eighth beat |
| conn_pulse | output | 1 | Connect decoded |
| conn_peer | output | 16 | Peer number of the connect |
| conn_vec | output | $clog2(NUM_VECS+1) | Vector slot assigned to the connect |
| conn_local | output | 1 | The connect is for the local peer (interrupt setup) |
| disc_pulse | output | 1 | Disconnect decoded |
| disc_peer | output | 16 | Peer number of the disconnect |
| mem_ready | output | 1 | Shared memory announced |
| setup_done | output | 1 | Setup sequence completed |
| local_id | output | 16 | Captured local identifier |
| peer_tbl_size | output | $clog2(MAX_PEERS+1) | Current peer table size |
| err_code | output | 3 | Most recent fault (0 means none) |

## Verification
The bench builds the decoder with PROTO_VER=5, MAX_PEERS=20, NUM_VECS=3 and INIT_PEERS=16. With these values a sweep can send a connect to every legal peer one time more than its vector limit, which makes all slot assignments and all rejections observable. Four peers lie beyond the initial table, so growth can be seen step by step, and the overflow boundary sits just past peer 19. Separate runs after reset cover every way setup can fail, a message split by idle gaps, and growth caused by a disconnect.

// File: rtl/peer_msg_pkg.sv
`timescale 1ns/1ps
package peer_msg_pkg;
  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_VERSION   = 3'd1,
    ERR_IDENT     = 3'd2,
    ERR_RANGE     = 3'd3,
    ERR_DUP_MEM   = 3'd4,
    ERR_VEC_FULL  = 3'd5,
    ERR_DISC_SELF = 3'd6,
    ERR_PEER_OVF  = 3'd7
  } err_e;

  typedef enum logic [2:0] {
    PH_VERSION,
    PH_IDENT,
    PH_WAIT_MEM,
    PH_RUN,
    PH_HALT
  } phase_e;
endpackage

// File: rtl/peer_msg_asm.sv
`timescale 1ns/1ps
module peer_msg_asm #(
  parameter int BYTES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  input  logic               in_handle,
  output logic               msg_valid,
  output logic [BYTES*8-1:0] msg_data,
  output logic               msg_handle
);
  localparam int MW = BYTES * 8;
  localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [CW-1:0] beat_cnt;
  logic [MW-1:0] shreg;
  logic          last_beat;

  assign last_beat = in_valid && (beat_cnt == CW'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt  <= '0;
      msg_valid <= 1'b0;
    end else begin
      msg_valid <= last_beat;
      if (in_valid) beat_cnt <= last_beat ? '0 : beat_cnt + 1'b1;
    end
  end

  // first byte ends at the bottom after BYTES shifts (little-endian)
  always_ff @(posedge clk) begin
    if (in_valid) shreg <= {in_byte, shreg[MW-1:8]};
    if (last_beat) begin
      msg_data   <= {in_byte, shreg[MW-1:8]};
      msg_handle <= in_handle;
    end
  end

  p_frame_r1: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> $past(in_valid));
  p_single_r1: assert property (@(posedge clk) disable iff (rst)
    msg_valid |=> !msg_valid);
endmodule

// File: rtl/peer_vec_table.sv
`timescale 1ns/1ps
module peer_vec_table #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CNTW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [CNTW-1:0] rd_cnt,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CNTW-1:0] wr_cnt
);
  logic [CNTW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [CNTW-1:0] cnt_q;
  logic            vld_q;

  // plain synchronous-read RAM, no reset on the array
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_cnt;
    if (rd_en) cnt_q <= mem[rd_addr];
  end

  // per-entry valid bits stand in for clearing the RAM at reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_en) vld[wr_addr] <= 1'b1;
      if (rd_en) vld_q <= vld[rd_addr];
    end
  end

  assign rd_cnt = vld_q ? cnt_q : '0;

  p_wr_range_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < DEPTH));
  p_no_rw_clash_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
endmodule

// File: rtl/peer_msg_ctrl.sv
`timescale 1ns/1ps
module peer_msg_ctrl
  import peer_msg_pkg::*;
#(
  parameter logic [63:0] PROTO_VER  = 64'd0,
  parameter int          MAX_PEERS  = 64,
  parameter int          NUM_VECS   = 2,
  parameter int          INIT_PEERS = 16,
  parameter int          AW         = 6,
  parameter int          CNTW       = 2,
  parameter int          TW         = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            msg_valid,
  input  logic [63:0]     msg_data,
  input  logic            msg_handle,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  input  logic [CNTW-1:0] rd_cnt,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [CNTW-1:0] wr_cnt,
  output logic            conn_pulse,
  output logic [15:0]     conn_peer,
  output logic [CNTW-1:0] conn_vec,
  output logic            conn_local,
  output logic            disc_pulse,
  output logic [15:0]     disc_peer,
  output logic            mem_ready,
  output logic            setup_done,
  output logic [15:0]     local_id,
  output logic [TW-1:0]   tbl_size,
  output err_e            err_code
);
  phase_e      phase;
  logic        eval_q;
  logic        is_m1, too_low, too_high, in_range, peer_ovf, vec_full, is_self, active;
  logic [15:0] peer;

  assign rd_en   = msg_valid;
  assign rd_addr = msg_data[AW-1:0];

  always_comb begin
    peer     = msg_data[15:0];
    is_m1    = &msg_data;
    too_low  = msg_data[63] && !is_m1;
    too_high = !msg_data[63] && (|msg_data[63:16]);
    in_range = !too_low && !too_high && !is_m1;
    peer_ovf = {16'd0, peer} >= 32'(MAX_PEERS);
    vec_full = rd_cnt >= CNTW'(NUM_VECS);
    is_self  = peer == local_id;
    active   = eval_q && (phase == PH_WAIT_MEM || phase == PH_RUN);
    wr_addr  = peer[AW-1:0];
    wr_cnt   = msg_handle ? rd_cnt + 1'b1 : '0;
    wr_en    = active && in_range && !peer_ovf &&
               (msg_handle ? !vec_full : !is_self);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_VERSION;
      eval_q     <= 1'b0;
      conn_pulse <= 1'b0;
      conn_peer  <= '0;
      conn_vec   <= '0;
      conn_local <= 1'b0;
      disc_pulse <= 1'b0;
      disc_peer  <= '0;
      mem_ready  <= 1'b0;
      setup_done <= 1'b0;
      local_id   <= '0;
      tbl_size   <= TW'(INIT_PEERS);
      err_code   <= ERR_NONE;
    end else begin
      eval_q     <= msg_valid;
      conn_pulse <= 1'b0;
      conn_local <= 1'b0;
      disc_pulse <= 1'b0;
      mem_ready  <= 1'b0;
      setup_done <= 1'b0;
      if (eval_q) begin
        case (phase)
          PH_VERSION: begin
            if (msg_handle || msg_data != PROTO_VER) begin
              err_code <= ERR_VERSION;
              phase    <= PH_HALT;
            end else begin
              phase <= PH_IDENT;
            end
          end
          PH_IDENT: begin
            if (msg_handle || msg_data[63] || (|msg_data[63:16])) begin
              err_code <= ERR_IDENT;
              phase    <= PH_HALT;
            end else begin
              local_id <= peer;
              phase    <= PH_WAIT_MEM;
            end
          end
          PH_WAIT_MEM, PH_RUN: begin
            if (too_low || too_high) begin
              err_code <= ERR_RANGE;
            end else if (is_m1) begin
              if (phase == PH_RUN) begin
                err_code <= ERR_DUP_MEM;
              end else begin
                mem_ready  <= 1'b1;
                setup_done <= 1'b1;
                phase      <= PH_RUN;
              end
            end else if (peer_ovf) begin
              err_code <= ERR_PEER_OVF;
            end else begin
              if (peer >= 16'(tbl_size)) tbl_size <= TW'(peer) + 1'b1;
              if (msg_handle) begin
                if (vec_full) begin
                  err_code <= ERR_VEC_FULL;
                end else begin
                  conn_pulse <= 1'b1;
                  conn_peer  <= peer;
                  conn_vec   <= rd_cnt;
                  conn_local <= is_self;
                end
              end else if (is_self) begin
                err_code <= ERR_DISC_SELF;
              end else begin
                disc_pulse <= 1'b1;
                disc_peer  <= peer;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_halt_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HALT) |=> (phase == PH_HALT));
  p_done_with_mem_r4: assert property (@(posedge clk) disable iff (rst)
    setup_done |-> mem_ready);
  p_vec_bound_r8: assert property (@(posedge clk) disable iff (rst)
    conn_pulse |-> (conn_vec < CNTW'(NUM_VECS)));
  p_disc_not_self_r9: assert property (@(posedge clk) disable iff (rst)
    disc_pulse |-> (disc_peer != local_id));
  p_tbl_grow_r10: assert property (@(posedge clk) disable iff (rst)
    tbl_size >= $past(tbl_size));
  p_tbl_cap_r11: assert property (@(posedge clk) disable iff (rst)
    32'(tbl_size) <= 32'(MAX_PEERS));
  p_one_event_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({conn_pulse, disc_pulse, mem_ready}));
  p_conn_short_r12: assert property (@(posedge clk) disable iff (rst)
    conn_pulse |=> !conn_pulse);
endmodule

// File: rtl/peer_msg_decoder.sv
`timescale 1ns/1ps
module peer_msg_decoder
  import peer_msg_pkg::*;
#(
  parameter logic [63:0] PROTO_VER  = 64'd0,
  parameter int          MAX_PEERS  = 64,
  parameter int          NUM_VECS   = 2,
  parameter int          INIT_PEERS = 16,
  localparam int         AW   = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1,
  localparam int         CNTW = $clog2(NUM_VECS + 1),
  localparam int         TW   = $clog2(MAX_PEERS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  input  logic            in_handle,
  output logic            conn_pulse,
  output logic [15:0]     conn_peer,
  output logic [CNTW-1:0] conn_vec,
  output logic            conn_local,
  output logic            disc_pulse,
  output logic [15:0]     disc_peer,
  output logic            mem_ready,
  output logic            setup_done,
  output logic [15:0]     local_id,
  output logic [TW-1:0]   peer_tbl_size,
  output logic [2:0]      err_code
);
  logic            msg_valid, msg_handle;
  logic [63:0]     msg_data;
  logic            rd_en, wr_en;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic [CNTW-1:0] rd_cnt, wr_cnt;
  err_e            err_q;

  peer_msg_asm #(.BYTES(8)) u_asm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_handle(in_handle), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_handle(msg_handle)
  );

  peer_vec_table #(.DEPTH(MAX_PEERS), .AW(AW), .CNTW(CNTW)) u_tbl (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_cnt(rd_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_cnt(wr_cnt)
  );

  peer_msg_ctrl #(
    .PROTO_VER(PROTO_VER), .MAX_PEERS(MAX_PEERS), .NUM_VECS(NUM_VECS),
    .INIT_PEERS(INIT_PEERS), .AW(AW), .CNTW(CNTW), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_handle(msg_handle), .rd_en(rd_en), .rd_addr(rd_addr), .rd_cnt(rd_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_cnt(wr_cnt),
    .conn_pulse(conn_pulse), .conn_peer(conn_peer), .conn_vec(conn_vec),
    .conn_local(conn_local), .disc_pulse(disc_pulse), .disc_peer(disc_peer),
    .mem_ready(mem_ready), .setup_done(setup_done), .local_id(local_id),
    .tbl_size(peer_tbl_size), .err_code(err_q)
  );

  assign err_code = err_q;
endmodule

// File: tb/peer_msg_decoder_tb.sv
`timescale 1ns/1ps
module peer_msg_decoder_tb;
  localparam logic [63:0] VER = 64'd5;
  localparam int MAXP = 20;
  localparam int NV   = 3;
  localparam int INIT = 16;
  localparam int CNTW = $clog2(NV + 1);
  localparam int TW   = $clog2(MAXP + 1);

  logic clk = 0, rst = 1, in_valid = 0, in_handle = 0;
  logic [7:0] in_byte = 0;
  logic conn_pulse, conn_local, disc_pulse, mem_ready, setup_done;
  logic [15:0] conn_peer, disc_peer, local_id;
  logic [CNTW-1:0] conn_vec;
  logic [TW-1:0] peer_tbl_size;
  logic [2:0] err_code;

  int n_run = 0, n_fail = 0;
  int n_conn = 0, n_disc = 0, n_mem = 0, n_done = 0, n_both = 0;
  int l_cpeer = 0, l_cvec = 0, l_clocal = 0, l_dpeer = 0;
  int exp_cnt [MAXP];
  int exp_tbl;

  always #5 clk = ~clk;

  peer_msg_decoder #(.PROTO_VER(VER), .MAX_PEERS(MAXP), .NUM_VECS(NV),
                     .INIT_PEERS(INIT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_handle(in_handle), .conn_pulse(conn_pulse), .conn_peer(conn_peer),
    .conn_vec(conn_vec), .conn_local(conn_local), .disc_pulse(disc_pulse),
    .disc_peer(disc_peer), .mem_ready(mem_ready), .setup_done(setup_done),
    .local_id(local_id), .peer_tbl_size(peer_tbl_size), .err_code(err_code)
  );

  always @(negedge clk) if (!rst) begin
    if (conn_pulse) begin
      n_conn++; l_cpeer = conn_peer; l_cvec = conn_vec; l_clocal = conn_local;
    end
    if (disc_pulse) begin n_disc++; l_dpeer = disc_peer; end
    if (mem_ready) n_mem++;
    if (setup_done) n_done++;
    if (mem_ready && setup_done) n_both++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    exp_tbl = INIT;
  endtask

  task automatic send_bytes(input logic [63:0] v, input logic h,
                            input int first, input int last, input int gap);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      in_valid = 1; in_byte = v[i*8 +: 8]; in_handle = (i == 7) ? h : 1'b0;
      for (int g = 0; g < gap; g++) begin @(negedge clk); in_valid = 0; end
    end
    @(negedge clk); in_valid = 0; in_handle = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] v, input logic h);
    send_bytes(v, h, 0, 7, 0);
  endtask

  task automatic connect_exp(input int p);
    int c0;
    c0 = n_conn;
    send(64'(p), 1'b1);
    if (p + 1 > exp_tbl) exp_tbl = p + 1;
    if (exp_cnt[p] < NV) begin
      chk("R7 conn event", n_conn - c0, 1);
      chk("R7 conn peer", l_cpeer, p);
      chk("R7 conn vec", l_cvec, exp_cnt[p]);
      chk("R7 conn local", l_clocal, (p == 2) ? 1 : 0);
      exp_cnt[p]++;
    end else begin
      chk("R8 full no event", n_conn - c0, 0);
      chk("R8 full err", err_code, 5);
    end
    chk("R10 table size", peer_tbl_size, exp_tbl);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int c0, d0, m0;
    // reset state
    do_reset();
    chk("R10 reset size", peer_tbl_size, INIT);
    chk("R2 reset err", err_code, 0);
    chk("R12 no pulses at reset", n_conn + n_disc + n_mem, 0);

    // R2: wrong version, then everything ignored
    send(64'd4, 0);
    chk("R2 bad version err", err_code, 1);
    send(VER, 0); send(64'd1, 0); send(64'd3, 1); send('1, 0);
    chk("R2 halted no events", n_conn + n_mem + n_done, 0);
    chk("R2 halted err kept", err_code, 1);
    do_reset();
    send(VER, 1);
    chk("R2 version with handle", err_code, 1);

    // R3: bad identifiers
    do_reset(); send(VER, 0); send(64'd70000, 0);
    chk("R3 id too big", err_code, 2);
    send('1, 0);
    chk("R3 halted no mem", n_mem, 0);
    do_reset(); send(VER, 0); send(-64'sd3, 0);
    chk("R3 negative id", err_code, 2);
    do_reset(); send(VER, 0); send(64'd3, 1);
    chk("R3 id with handle", err_code, 2);
    do_reset(); send(VER, 0); send(64'd65535, 0);
    chk("R3 max id ok", local_id, 65535);
    chk("R3 max id no err", err_code, 0);

    // main run, local id 2, version sent with idle gaps (R1)
    do_reset();
    send_bytes(VER, 0, 0, 7, 2);
    chk("R1 gapped version accepted", err_code, 0);
    send(64'd2, 0);
    chk("R3 local id", local_id, 2);
    connect_exp(7);
    m0 = n_mem;
    send_bytes('1, 0, 0, 6, 0);
    chk("R1 partial not decoded", n_mem - m0, 0);
    send_bytes('1, 0, 7, 7, 0);
    chk("R4 mem ready", n_mem - m0, 1);
    chk("R4 setup done", n_done, 1);
    chk("R4 same cycle", n_both, 1);

    // R7/R8/R10 sweep
    for (int p = 0; p < MAXP; p++)
      for (int j = 0; j <= NV; j++) connect_exp(p);

    // R9 disconnect
    d0 = n_disc;
    send(64'd1, 0);
    chk("R9 disc event", n_disc - d0, 1);
    chk("R9 disc peer", l_dpeer, 1);
    exp_cnt[1] = 0;
    connect_exp(1);
    d0 = n_disc;
    send(64'd2, 0);
    chk("R9 disc self err", err_code, 6);
    chk("R9 disc self no event", n_disc - d0, 0);
    connect_exp(2);

    // R11 overflow
    c0 = n_conn;
    send(64'(MAXP), 1);
    chk("R11 ovf err", err_code, 7);
    chk("R11 ovf no event", n_conn - c0, 0);
    chk("R11 table kept", peer_tbl_size, MAXP);
    send(64'd3, 1);
    chk("R11 err after reject", err_code, 5);
    d0 = n_disc;
    send(64'd65535, 0);
    chk("R11 ovf disc err", err_code, 7);
    chk("R11 ovf disc no event", n_disc - d0, 0);

    // R5 range
    c0 = n_conn; d0 = n_disc; m0 = n_mem;
    send(64'd65536, 1);
    chk("R5 too high err", err_code, 3);
    send(64'd0, 1);
    send(-64'sd2, 0);
    chk("R5 too low err", err_code, 3);
    chk("R5 no events", (n_conn - c0) + (n_disc - d0) + (n_mem - m0), 0);

    // R6 duplicate memory
    send('1, 0);
    chk("R6 dup mem err", err_code, 4);
    chk("R6 no second mem", n_mem - m0, 0);
    chk("R12 pulses one per message", n_done, 1);

    // R10 growth by disconnect
    do_reset(); send(VER, 0); send(64'd0, 0); send('1, 0);
    d0 = n_disc;
    send(64'd18, 0);
    chk("R10 disc grows", peer_tbl_size, 19);
    chk("R9 disc new peer", n_disc - d0, 1);
    connect_exp(18);

    summary();
  end
endmodule